// File: doc/BRIEF.md
# Registered bus driver with parity check

A 12-bit bus driver whose every input bit feeds two identical output copies. A path select chooses between a transparent buffer and a rising-edge register. A bank control decides whether the register captures the whole word or only its top four bits. The output enable floats both copies and the error flag without disturbing any internal state.

Alongside the data path runs a pipelined parity checker. The parity bit for a word arrives one cycle after the word, and the stored result shows on an open-drain style error flag one cycle after that. One data bit also serves as the active-low load enable of the error register. A bidirectional partial-sum pin lets two instances split one 24-bit check: one instance sends the parity of its half, and the other folds it in. In single use the level on that pin picks even or odd sense.

Top module: `pbus_driver`

## Requirements
- R1: While `oe_n` is 0, `ya` and `yb` always carry the same 12-bit value.
- R2: With `pass_mode` = 1 and `oe_n` = 0, `ya` equals the current `din` within the same cycle.
- R3: With `pass_mode` = 0, the outputs show the register, and a rising edge with `upper_only` = 0 loads all 12 bits of `din`.
- R4: A rising edge with `upper_only` = 1 loads only `din[11:8]`, and register bits [7:0] keep their values.
- R5: The register captures on every rising edge under the rules of R3/R4, whatever the value of `pass_mode`.
- R6: With `sum_oe_n` = 1, a mismatch is the XOR of the 12 bits of `din` captured at the previous edge, `par_in` and the `psum` level (0 = even sense, 1 = odd sense). The mismatch is stored at the edge that samples `par_in`, and `err_n` shows it after that edge.
- R7: The error register loads at an edge only if `din[10]` is 0 at that edge. If `din[10]` is 1 it holds its value.
- R8: With `sum_oe_n` = 0, the block drives `psum` with the XOR of the 12 bits of `din` captured at the previous edge. Its own error register loads "no mismatch" when it loads.
- R9: Two instances sharing `psum`, one sending and one receiving, give the receiver an even-parity check over all 24 data bits plus its `par_in`.
- R10: With `oe_n` = 1, `ya`, `yb` and `err_n` are high impedance, while the register, the parity stage and the error register keep updating.
- R11: `err_n` drives 0 only when a mismatch is stored and `oe_n` = 0. Otherwise it is high impedance and never drives 1.
- R12: A synchronous reset (`rst` = 1 at an edge) clears the data register, the parity stage and the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pass_mode | input | 1 | 1 = transparent buffer, 0 = registered path |
| upper_only | input | 1 | 1 = capture bits [11:8] only, 0 = capture all bits |
| oe_n | input | 1 | Output enable for both copies and the error flag, active low |
| din | input | 12 | Data word; bit 10 also gates the error register (active low) |
| par_in | input | 1 | Parity bit for the word captured one edge earlier |
| sum_oe_n | input | 1 | 0 = send partial sum on `psum`, 1 = read `psum` |
| psum | inout | 1 | Parity sense input or partial-sum input/output |
| ya | output | 12 | First data copy, tri-state |
| yb | output | 12 | Second data copy, tri-state |
| err_n | output | 1 | Parity mismatch flag: drives 0 or floats |

## Verification
Bit 10 of `din` has two jobs. At a single edge it is captured as data (or passed straight through) and it also decides whether the error register takes the verdict on the previous word. Meanwhile the parity bit of that previous word arrives in the same cycle as the new word. An exhaustive run over all 4096 input words, with the parity bit supplied one cycle late, makes every word act at once as data, as error-register gate and as the carrier of its predecessor's check. Output copies, mode, bank control, sense, output enable and injected single-bit errors are varied from the word's own bits, and each cycle is judged against an arithmetic model kept in the bench. A second phase repeats the overlap with two cascaded instances and checks the receiver's flag against a 24-bit parity.

// File: rtl/pbd_pkg.sv
`timescale 1ns/1ps
package pbd_pkg;
    parameter int unsigned DATA_W     = 12;
    parameter int unsigned LOW_BANK   = 8;
    parameter int unsigned ERR_EN_BIT = 10;
    parameter int unsigned N_COPIES   = 2;

    typedef enum logic {
        PATH_REG = 1'b0,
        PATH_BUF = 1'b1
    } path_e;
endpackage

// File: rtl/pbd_datapath.sv
`timescale 1ns/1ps
module pbd_datapath
    import pbd_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned LB = LOW_BANK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upper_only,
    input  logic          path_sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sel_val
);
    typedef struct packed {
        logic [DW-1:0] data;
    } dp_st_t;

    dp_st_t        st_d, st_q;
    logic [DW-1:0] ld_en;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b >= LB) begin : g_upper
            assign ld_en[b] = 1'b1;
        end else begin : g_lower
            assign ld_en[b] = ~upper_only;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DW; i++) begin
            if (ld_en[i]) st_d.data[i] = din[i];
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_val = (path_e'(path_sel) == PATH_BUF) ? din : st_q.data;

    // R3 R5
    full_load_chk: assert property (@(posedge clk) disable iff (rst)
        !upper_only |=> st_q.data == $past(din));
    // R4
    lower_keep_chk: assert property (@(posedge clk) disable iff (rst)
        upper_only |=> st_q.data[LB-1:0] == $past(st_q.data[LB-1:0]));
    // R4
    upper_load_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> st_q.data[DW-1:LB] == $past(din[DW-1:LB]));
    // R12
    dp_reset_chk: assert property (@(posedge clk)
        rst |=> st_q.data == '0);
endmodule

// File: rtl/pbd_parity.sv
`timescale 1ns/1ps
module pbd_parity
    import pbd_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          err_gate_n,
    input  logic          par_bit,
    input  logic          sum_oe_n,
    input  logic          sense_in,
    output logic          part_sum,
    output logic          mism
);
    typedef struct packed {
        logic [DW-1:0] prev;
        logic          mism;
    } par_st_t;

    par_st_t st_d, st_q;
    logic    own_sum;
    logic    fold;

    assign own_sum = ^st_q.prev;
    assign fold    = sum_oe_n ? sense_in : 1'b0;

    always_comb begin
        st_d      = st_q;
        st_d.prev = din;
        if (!err_gate_n) begin
            st_d.mism = sum_oe_n ? (own_sum ^ par_bit ^ fold) : 1'b0;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign part_sum = own_sum;
    assign mism     = st_q.mism;

    // R6
    prev_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> st_q.prev == $past(din));
    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_gate_n |=> $stable(st_q.mism));
    // R8
    sender_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_gate_n && !sum_oe_n) |=> !st_q.mism);
    // R12
    par_reset_chk: assert property (@(posedge clk)
        rst |=> (st_q.prev == '0 && !st_q.mism));
endmodule

// File: rtl/pbd_outdrv.sv
`timescale 1ns/1ps
module pbd_outdrv
    import pbd_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NC = N_COPIES
) (
    input  logic             oe_n,
    input  logic [DW-1:0]    val,
    input  logic             mism,
    output logic [NC*DW-1:0] cp_val,
    output logic             cp_en,
    output logic             err_low
);
    for (genvar c = 0; c < NC; c++) begin : g_copy
        assign cp_val[c*DW +: DW] = val;
    end

    assign cp_en   = ~oe_n;
    assign err_low = ~oe_n & mism;
endmodule

// File: rtl/pbus_driver.sv
`timescale 1ns/1ps
module pbus_driver
    import pbd_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned LB  = LOW_BANK,
    parameter int unsigned EEB = ERR_EN_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pass_mode,
    input  logic          upper_only,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    input  logic          par_in,
    input  logic          sum_oe_n,
    inout  wire           psum,
    output wire  [DW-1:0] ya,
    output wire  [DW-1:0] yb,
    output wire           err_n
);
    localparam int unsigned NC = 2;

    logic [DW-1:0]    sel_val;
    logic             part_sum;
    logic             mism;
    logic [NC*DW-1:0] cp_val;
    logic             cp_en;
    logic             err_low;

    pbd_datapath #(.DW(DW), .LB(LB)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .upper_only (upper_only),
        .path_sel   (pass_mode),
        .din        (din),
        .sel_val    (sel_val)
    );

    pbd_parity #(.DW(DW)) u_par (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .err_gate_n (din[EEB]),
        .par_bit    (par_in),
        .sum_oe_n   (sum_oe_n),
        .sense_in   (psum),
        .part_sum   (part_sum),
        .mism       (mism)
    );

    pbd_outdrv #(.DW(DW), .NC(NC)) u_out (
        .oe_n    (oe_n),
        .val     (sel_val),
        .mism    (mism),
        .cp_val  (cp_val),
        .cp_en   (cp_en),
        .err_low (err_low)
    );

    assign psum  = sum_oe_n ? 1'bz : part_sum;
    assign ya    = cp_en ? cp_val[0 +: DW]  : {DW{1'bz}};
    assign yb    = cp_en ? cp_val[DW +: DW] : {DW{1'bz}};
    assign err_n = err_low ? 1'b0 : 1'bz;

    // R1
    copies_match_chk: assert property (@(posedge clk) disable iff (rst)
        cp_val[DW +: DW] == cp_val[0 +: DW]);
    // R2
    pass_path_chk: assert property (@(posedge clk) disable iff (rst)
        pass_mode |-> sel_val == din);
    // R11
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        err_low |-> (mism && !oe_n));
endmodule

// File: tb/sim_pbus_driver.sv
`timescale 1ns/1ps
module sim_pbus_driver;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] din0, dinb;
    logic        par0, pass0, hold0, oe0;
    logic        u1_soe_n, tb_drv, tb_sense;
    tri1  [11:0] ya0, yb0, ya1, yb1;
    tri1         err0, err1;
    wire         psum_w;

    int n_tests = 0;
    int n_fail  = 0;

    logic [11:0] m_reg, m_prev, m_prevb;
    logic        m_err;
    logic        last_hold, last_pass, last_gate;
    int          casc_age;

    assign psum_w = tb_drv ? tb_sense : 1'bz;

    always #2.5 clk = ~clk;

    pbus_driver u0 (
        .clk(clk), .rst(rst), .pass_mode(pass0), .upper_only(hold0), .oe_n(oe0),
        .din(din0), .par_in(par0), .sum_oe_n(1'b1), .psum(psum_w),
        .ya(ya0), .yb(yb0), .err_n(err0)
    );

    pbus_driver u1 (
        .clk(clk), .rst(rst), .pass_mode(1'b1), .upper_only(1'b0), .oe_n(1'b0),
        .din(dinb), .par_in(1'b0), .sum_oe_n(u1_soe_n), .psum(psum_w),
        .ya(ya1), .yb(yb1), .err_n(err1)
    );

    task automatic chk12(input logic [11:0] act, input logic [11:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one cycle: drive at edge+1, check at edge+2, advance model at the edge
    task automatic cyc(input logic [11:0] d, input logic p, input logic pass,
                       input logic hold, input logic oe, input logic sense,
                       input logic casc, input logic [11:0] db);
        logic [11:0] exp_y;
        logic        mis;
        string       yreq, ereq;
        din0 = d; par0 = p; pass0 = pass; hold0 = hold; oe0 = oe;
        tb_sense = sense; tb_drv = !casc; u1_soe_n = !casc; dinb = db;
        #1;
        // oe released -> pulled-up nets read all ones (R10)
        exp_y = oe ? 12'hFFF : (pass ? d : m_reg);
        if (oe)             yreq = "R10";
        else if (pass)      yreq = "R2";
        else if (last_pass) yreq = "R5";
        else if (last_hold) yreq = "R4";
        else                yreq = "R3";
        chk12(ya0, exp_y, yreq);
        chk12(yb0, exp_y, "R1");
        if (oe)             ereq = "R10";
        else if (casc)      ereq = "R9";
        else if (last_gate) ereq = "R7";
        else if (m_err)     ereq = "R6";
        else                ereq = "R11";
        chk1(err0, (oe || !m_err), ereq);
        if (casc) begin
            chk1(psum_w, ^m_prevb, "R8");
            if (casc_age >= 1) chk1(err1, 1'b1, "R8");
        end
        @(posedge clk);
        mis = (^m_prev) ^ p ^ (casc ? (^m_prevb) : sense);
        if (!d[10]) m_err = mis;
        m_reg     = hold ? {d[11:8], m_reg[7:0]} : d;
        m_prev    = d;
        m_prevb   = db;
        last_hold = hold;
        last_pass = pass;
        last_gate = d[10];
        casc_age  = casc ? casc_age + 1 : 0;
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        rst = 1'b1; din0 = 12'hA5A; dinb = 12'h3C3; par0 = 1'b1;
        pass0 = 1'b0; hold0 = 1'b0; oe0 = 1'b0;
        u1_soe_n = 1'b1; tb_drv = 1'b1; tb_sense = 1'b0;
        m_reg = '0; m_prev = '0; m_prevb = '0; m_err = 1'b0;
        last_hold = 1'b0; last_pass = 1'b0; last_gate = 1'b0; casc_age = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R12: register cleared, flag released
        chk12(ya0, 12'h000, "R12");
        chk1(err0, 1'b1, "R12");

        // exhaustive sweep over every data word
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] w;
            logic        sn, inj;
            w   = v[11:0];
            sn  = w[0] ^ w[5];
            inj = w[3] & w[7] & w[11];
            cyc(w, (^m_prev) ^ sn ^ inj, w[1], w[2], w[4] & w[9], sn, 1'b0, 12'h000);
        end

        // R7: set a mismatch, then hold it with gate inactive
        cyc(12'h123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        cyc(12'h000, ~(^12'h123), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        cyc(12'h400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        cyc(12'h7FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        cyc(12'h000, ^12'h7FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        cyc(12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);

        // R10: load while floated, then reveal
        cyc(12'h9B6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
        cyc(12'h012, ^12'h9B6 ^ 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        cyc(12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);

        // R9: cascade of two instances, reference over 24 bits
        seed = 32'h1234_5678;
        for (int k = 0; k < 600; k++) begin
            logic [11:0] db;
            logic        inj;
            seed = seed * 32'd1664525 + 32'd1013904223;
            db   = seed[23:12] & 12'hBFF;
            inj  = seed[24] & seed[25];
            cyc(seed[11:0], (^m_prev) ^ (^m_prevb) ^ inj, seed[26], seed[27],
                seed[28] & seed[29], 1'b0, 1'b1, db);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule